// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects up to 64 interrupt request lines and decides which of them the processor should take next. Each line has three state bits: a latched bit that records every raise, an enable bit, and an enabled-pending bit. Each line also has an 8-bit urgency value, where a smaller number is more urgent. A 9-bit register holds the urgency of the handler that is currently running. A request has to beat that value to be reported.

Software drives the block through a one-cycle command port. The commands enable or disable a line, write an urgency value, write the running level, write the global lock, and clear pending state in bulk. Single-cycle pulse vectors raise or clear individual lines. A separate pulse arms a one-shot override, which lets the next hardware wake through a held lock.

The block has three result outputs: a one-cycle wake pulse, a registered winner number, and a winner-valid flag. The block carries no streaming data, so it has no valid/ready handshake. Every pin is a plain control or status signal that is sampled on the rising clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `raise_i[i]` always sets latched bit i (`premask_o[i]`). It sets pending bit i (`pend_o[i]`) only if enable bit i is 1 after this cycle's command has taken effect.
- R2: An enable command for a line whose latched bit was already 1 sets that line's pending bit. If the lock is clear, it also produces a `wake_o` pulse in the next cycle. No new raise is needed.
- R3: Urgency values are 8 bits, and 0 is the most urgent. The running level is 9 bits, and 256 means no handler is active. A line is eligible only if its urgency is strictly less than the running level. `rd_prio_o` returns the urgency of line `rd_line_i` combinationally.
- R4: The winner is chosen among lines whose pending and enable bits are both 1. It is the eligible line with the smallest urgency, and on a tie the lower line number wins. `win_vld_o` and `win_id_o` are registered one cycle after the state they reflect. When there is no winner, `win_vld_o` is 0 and `win_id_o` is all ones (127).
- R5: While the lock is set, raises are still recorded. However, no winner is reported, and neither raises nor enables produce a wake.
- R6: A lock write that changes the lock from 1 to 0 produces a wake pulse if the pending vector is non-zero after that cycle's updates. Every lock write loads the lock's previous value into `prev_lock_o`.
- R7: Clear-line pulses (`clr_i`) clear both the pending bit and the latched bit of a line. The clear-enabled command zeroes the pending vector and clears only the latched bits of enabled lines. The clear-all command zeroes both vectors.
- R8: Reset sets the following values: all enable, latched and pending bits are 0, the lock and the override flag are 0, every urgency is 255, the running level is 256, and there is no wake and no winner.
- R9: `hard_req_i` sets the override flag (`bypass_o`). The next hardware raise then produces a wake even if the lock is held, and that wake clears the flag.
- R10: A hardware raise produces a wake even when the raised line is disabled, provided the lock is clear or the override flag is set.
- R11: If a raise and a clear reach the same line in the same cycle, the raise wins and the latched bit ends at 1.
- R12: The command codes on `cmd_op_i` are: 0 no operation, 1 enable line, 2 disable line, 3 write urgency (data[7:0]), 4 write running level (data[8:0]), 5 write lock (data[0]), 6 clear enabled, 7 clear all. In every command the bit number of a line equals its line number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| raise_i | input | 64 | Per-line hardware raise pulses |
| clr_i | input | 64 | Per-line clear pulses |
| hard_req_i | input | 1 | Arms the one-shot lock override |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_line_i | input | 6 | Line addressed by the command |
| cmd_data_i | input | 9 | Command data |
| rd_line_i | input | 6 | Line whose urgency is read |
| rd_prio_o | output | 8 | Urgency of `rd_line_i` |
| mask_o | output | 64 | Enable bits |
| premask_o | output | 64 | Latched raise bits |
| pend_o | output | 64 | Enabled-pending bits |
| lock_o | output | 1 | Global lock |
| bypass_o | output | 1 | Override flag |
| prev_lock_o | output | 1 | Lock value before the last lock write |
| run_prio_o | output | 9 | Running handler level |
| wake_o | output | 1 | One-cycle wake pulse |
| win_vld_o | output | 1 | Winner valid |
| win_id_o | output | 7 | Winner line, all ones when none |

## Verification
The assertions check the following on every cycle:
- Any reported winner was pending, enabled and strictly below the running level.
- A held lock yields no winner on the next cycle and, without the override or an unlock, no wake.
- A raise always lands in the latched vector.
- Clear-all empties both vectors.
- The override is consumed by the wake it lets through.

Some behaviours are shown only by the bench's scenarios and its cycle-accurate reference model:
- The winner is the minimum-urgency line, and ties go to the lower line number.
- An enable re-raises a line that was already latched.
- An unlock produces a wake only when something is pending.
- Clear-enabled treats enabled and disabled lines differently.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ENABLE  = 3'd1,
    OP_DISABLE = 3'd2,
    OP_PRIO    = 3'd3,
    OP_RUN     = 3'd4,
    OP_LOCK    = 3'd5,
    OP_CLR_EN  = 3'd6,
    OP_CLR_ALL = 3'd7
  } irqc_op_e;
endpackage

// File: rtl/irqc_vectors.sv
module irqc_vectors #(
  parameter int N   = 64,
  parameter int IDW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   raise_i,
  input  logic [N-1:0]   clr_i,
  input  logic           en_cmd,
  input  logic           dis_cmd,
  input  logic           clr_en_cmd,
  input  logic           clr_all_cmd,
  input  logic [IDW-1:0] line_i,
  output logic [N-1:0]   mask_q,
  output logic [N-1:0]   premask_q,
  output logic [N-1:0]   pend_q,
  output logic [N-1:0]   pend_nxt,
  output logic           latched_hit
);
  logic [N-1:0] sel;
  logic [N-1:0] mask_nxt;
  logic [N-1:0] pre_nxt;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic m_n, p_n, q_n;
    assign sel[i] = (line_i == IDW'(i));

    always_comb begin
      m_n = mask_q[i];
      if (en_cmd && sel[i])       m_n = 1'b1;
      else if (dis_cmd && sel[i]) m_n = 1'b0;

      p_n = premask_q[i] & ~clr_i[i];
      q_n = pend_q[i] & ~clr_i[i];
      if (clr_all_cmd) begin
        p_n = 1'b0;
        q_n = 1'b0;
      end else if (clr_en_cmd) begin
        q_n = 1'b0;
        if (mask_q[i]) p_n = 1'b0;
      end

      // raises are applied after clears so an edge is never lost
      if (raise_i[i]) begin
        p_n = 1'b1;
        if (m_n) q_n = 1'b1;
      end
      // enabling an already latched line re-raises it
      if (en_cmd && sel[i] && premask_q[i]) q_n = 1'b1;
    end

    assign mask_nxt[i] = m_n;
    assign pre_nxt[i]  = p_n;
    assign pend_nxt[i] = q_n;
  end

  assign latched_hit = en_cmd & |(sel & premask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      premask_q <= '0;
      pend_q    <= '0;
    end else begin
      mask_q    <= mask_nxt;
      premask_q <= pre_nxt;
      pend_q    <= pend_nxt;
    end
  end
endmodule

// File: rtl/irqc_prio_bank.sv
module irqc_prio_bank #(
  parameter int N   = 64,
  parameter int PW  = 8,
  parameter int IDW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [IDW-1:0]  wr_line_i,
  input  logic [PW-1:0]   wr_val_i,
  input  logic [IDW-1:0]  rd_line_i,
  output logic [PW-1:0]   rd_val_o,
  output logic [N*PW-1:0] prio_flat_o
);
  logic [PW-1:0] prio_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               prio_arr[i] <= '1;
      else if (wr_i && (wr_line_i == IDW'(i)))  prio_arr[i] <= wr_val_i;
    end
    assign prio_flat_o[i*PW +: PW] = prio_arr[i];
  end

  assign rd_val_o = prio_arr[rd_line_i];
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N   = 64,
  parameter int PW  = 8,
  parameter int IDW = 6,
  localparam int RW = PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_flat_i,
  input  logic [RW-1:0]   run_i,
  input  logic            lock_i,
  output logic            vld_o,
  output logic [IDW:0]    id_o
);
  logic [RW-1:0]  best;
  logic [IDW-1:0] best_id;
  logic           found;

  // strict less-than keeps the lower line on a tie; seeding with the
  // running level folds the "must beat the running handler" test in
  always_comb begin
    best    = run_i;
    best_id = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && ({1'b0, prio_flat_i[i*PW +: PW]} < best)) begin
        best    = {1'b0, prio_flat_i[i*PW +: PW]};
        best_id = IDW'(i);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      id_o  <= '1;
    end else if (found && !lock_i) begin
      vld_o <= 1'b1;
      id_o  <= {1'b0, best_id};
    end else begin
      vld_o <= 1'b0;
      id_o  <= '1;
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl #(
  parameter int PW  = 8,
  localparam int RW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_raise_i,
  input  logic          hard_req_i,
  input  logic          latched_hit_i,
  input  logic          pend_any_nxt_i,
  input  logic          lock_wr_i,
  input  logic          lock_val_i,
  input  logic          run_wr_i,
  input  logic [RW-1:0] run_val_i,
  output logic          lock_q,
  output logic          byp_q,
  output logic          prev_q,
  output logic [RW-1:0] run_q,
  output logic          wake_q
);
  localparam logic [RW-1:0] RUN_IDLE = {1'b1, {PW{1'b0}}};

  logic hw_go;
  logic sw_go;
  logic unlock_go;

  assign hw_go     = hw_raise_i & (~lock_q | byp_q);
  assign sw_go     = latched_hit_i & ~lock_q;
  assign unlock_go = lock_wr_i & lock_q & ~lock_val_i & pend_any_nxt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      byp_q  <= 1'b0;
      prev_q <= 1'b0;
      run_q  <= RUN_IDLE;
      wake_q <= 1'b0;
    end else begin
      wake_q <= hw_go | sw_go | unlock_go;
      byp_q  <= hard_req_i | (byp_q & ~hw_go);
      if (lock_wr_i) begin
        lock_q <= lock_val_i;
        prev_q <= lock_q;
      end
      if (run_wr_i) run_q <= run_val_i;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N   = 64,
  parameter int PW  = 8,
  localparam int IDW = $clog2(N),
  localparam int RW  = PW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   raise_i,
  input  logic [N-1:0]   clr_i,
  input  logic           hard_req_i,
  input  logic           cmd_vld_i,
  input  logic [2:0]     cmd_op_i,
  input  logic [IDW-1:0] cmd_line_i,
  input  logic [RW-1:0]  cmd_data_i,
  input  logic [IDW-1:0] rd_line_i,
  output logic [PW-1:0]  rd_prio_o,
  output logic [N-1:0]   mask_o,
  output logic [N-1:0]   premask_o,
  output logic [N-1:0]   pend_o,
  output logic           lock_o,
  output logic           bypass_o,
  output logic           prev_lock_o,
  output logic [RW-1:0]  run_prio_o,
  output logic           wake_o,
  output logic           win_vld_o,
  output logic [IDW:0]   win_id_o
);
  import irqc_pkg::*;

  irqc_op_e        op;
  logic            is_en, is_dis, is_prio, is_run, is_lock, is_clr_en, is_clr_all;
  logic [N-1:0]    pend_nxt;
  logic            latched_hit;
  logic [N*PW-1:0] prio_flat;

  assign op         = irqc_op_e'(cmd_op_i);
  assign is_en      = cmd_vld_i && (op == OP_ENABLE);
  assign is_dis     = cmd_vld_i && (op == OP_DISABLE);
  assign is_prio    = cmd_vld_i && (op == OP_PRIO);
  assign is_run     = cmd_vld_i && (op == OP_RUN);
  assign is_lock    = cmd_vld_i && (op == OP_LOCK);
  assign is_clr_en  = cmd_vld_i && (op == OP_CLR_EN);
  assign is_clr_all = cmd_vld_i && (op == OP_CLR_ALL);

  irqc_vectors #(.N(N), .IDW(IDW)) u_vec (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_i     (raise_i),
    .clr_i       (clr_i),
    .en_cmd      (is_en),
    .dis_cmd     (is_dis),
    .clr_en_cmd  (is_clr_en),
    .clr_all_cmd (is_clr_all),
    .line_i      (cmd_line_i),
    .mask_q      (mask_o),
    .premask_q   (premask_o),
    .pend_q      (pend_o),
    .pend_nxt    (pend_nxt),
    .latched_hit (latched_hit)
  );

  irqc_prio_bank #(.N(N), .PW(PW), .IDW(IDW)) u_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (is_prio),
    .wr_line_i   (cmd_line_i),
    .wr_val_i    (cmd_data_i[PW-1:0]),
    .rd_line_i   (rd_line_i),
    .rd_val_o    (rd_prio_o),
    .prio_flat_o (prio_flat)
  );

  irqc_ctrl #(.PW(PW)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_raise_i     (|raise_i),
    .hard_req_i     (hard_req_i),
    .latched_hit_i  (latched_hit),
    .pend_any_nxt_i (|pend_nxt),
    .lock_wr_i      (is_lock),
    .lock_val_i     (cmd_data_i[0]),
    .run_wr_i       (is_run),
    .run_val_i      (cmd_data_i),
    .lock_q         (lock_o),
    .byp_q          (bypass_o),
    .prev_q         (prev_lock_o),
    .run_q          (run_prio_o),
    .wake_q         (wake_o)
  );

  irqc_arb #(.N(N), .PW(PW), .IDW(IDW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (pend_o & mask_o),
    .prio_flat_i (prio_flat),
    .run_i       (run_prio_o),
    .lock_i      (lock_o),
    .vld_o       (win_vld_o),
    .id_o        (win_id_o)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N   = 64,
  parameter int PW  = 8,
  localparam int IDW = $clog2(N),
  localparam int RW  = PW + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    raise_i,
  input logic            hard_req_i,
  input logic            cmd_vld_i,
  input logic [2:0]      cmd_op_i,
  input logic            lock_o,
  input logic            bypass_o,
  input logic            wake_o,
  input logic            win_vld_o,
  input logic [IDW:0]    win_id_o,
  input logic [N-1:0]    pend_o,
  input logic [N-1:0]    premask_o,
  input logic [N-1:0]    mask_o,
  input logic [RW-1:0]   run_prio_o,
  input logic [N*PW-1:0] prio_flat
);
  import irqc_pkg::*;

  logic [N*PW-1:0] prio_d;
  logic [N-1:0]    req_d;
  logic [RW-1:0]   run_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_d <= '1;
      req_d  <= '0;
      run_d  <= {1'b1, {PW{1'b0}}};
    end else begin
      prio_d <= prio_flat;
      req_d  <= pend_o & mask_o;
      run_d  <= run_prio_o;
    end
  end

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (!win_id_o[IDW] && req_d[win_id_o[IDW-1:0]] &&
                   ({1'b0, prio_d[win_id_o[IDW-1:0]*PW +: PW]} < run_d))); // R4

  AST_LOCK_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> !win_vld_o); // R5

  AST_LOCK_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !bypass_o && !(cmd_vld_i && cmd_op_i == OP_LOCK)) |=> !wake_o); // R5

  AST_RAISE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_i) |=> ((premask_o & $past(raise_i)) == $past(raise_i))); // R11

  AST_CLR_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && cmd_op_i == OP_CLR_ALL && raise_i == '0) |=>
      (pend_o == '0 && premask_o == '0)); // R7

  AST_BYPASS_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_o && (|raise_i) && !hard_req_i) |=> (wake_o && !bypass_o)); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N), .PW(PW)) u_chk (.*);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int N = 64, PW = 8, IDW = 6, RW = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [N-1:0]   raise_i = '0, clr_i = '0;
  logic           hard_req_i = 1'b0, cmd_vld_i = 1'b0;
  logic [2:0]     cmd_op_i = '0;
  logic [IDW-1:0] cmd_line_i = '0, rd_line_i = '0;
  logic [RW-1:0]  cmd_data_i = '0;
  logic [PW-1:0]  rd_prio_o;
  logic [N-1:0]   mask_o, premask_o, pend_o;
  logic           lock_o, bypass_o, prev_lock_o, wake_o, win_vld_o;
  logic [RW-1:0]  run_prio_o;
  logic [IDW:0]   win_id_o;

  prio_irq_ctrl dut (.*);

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  bit [63:0] m_pre, m_pend, m_mask;
  int        m_prio [N];
  int        m_run, m_id;
  bit        m_lock, m_byp, m_prev, m_wake, m_vld;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pre = 0; m_pend = 0; m_mask = 0;
    for (int i = 0; i < N; i++) m_prio[i] = 255;
    m_run = 256; m_lock = 0; m_byp = 0; m_prev = 0; m_wake = 0;
    m_vld = 0; m_id = 127;
  endtask

  task automatic model_step();
    bit [63:0] mask_n, pre_n, pend_n, bit_l;
    bit hw, hw_go, w;
    int l, best, bid;
    l = int'(cmd_line_i);
    bit_l = 64'd1 << l;
    mask_n = m_mask;
    if (cmd_vld_i && cmd_op_i == 3'd1) mask_n |= bit_l;
    if (cmd_vld_i && cmd_op_i == 3'd2) mask_n &= ~bit_l;
    pre_n = m_pre & ~clr_i;
    pend_n = m_pend & ~clr_i;
    if (cmd_vld_i && cmd_op_i == 3'd7) begin pre_n = 0; pend_n = 0; end
    else if (cmd_vld_i && cmd_op_i == 3'd6) begin pend_n = 0; pre_n &= ~m_mask; end
    pre_n |= raise_i;
    pend_n |= raise_i & mask_n;
    w = 0;
    if (cmd_vld_i && cmd_op_i == 3'd1 && (m_pre & bit_l) != 0) begin
      pend_n |= bit_l;
      if (!m_lock) w = 1;
    end
    hw = (raise_i != 0);
    hw_go = hw && (!m_lock || m_byp);
    if (hw_go) w = 1;
    if (cmd_vld_i && cmd_op_i == 3'd5 && m_lock && !cmd_data_i[0] && pend_n != 0) w = 1;
    // winner from the state before this edge
    best = m_run; bid = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_mask[i] && m_prio[i] < best) begin best = m_prio[i]; bid = i; end
    if (bid >= 0 && !m_lock) begin m_vld = 1; m_id = bid; end
    else begin m_vld = 0; m_id = 127; end
    m_wake = w;
    m_byp = hard_req_i || (m_byp && !hw_go);
    if (cmd_vld_i && cmd_op_i == 3'd5) begin m_prev = m_lock; m_lock = cmd_data_i[0]; end
    if (cmd_vld_i && cmd_op_i == 3'd3) m_prio[l] = int'(cmd_data_i[7:0]);
    if (cmd_vld_i && cmd_op_i == 3'd4) m_run = int'(cmd_data_i);
    m_mask = mask_n; m_pre = pre_n; m_pend = pend_n;
  endtask

  task automatic compare_all();
    chk("R1", "premask", premask_o, m_pre);
    chk("R1", "pending", pend_o, m_pend);
    chk("R12", "mask", mask_o, m_mask);
    chk("R10", "wake", 64'(wake_o), 64'(m_wake));
    chk("R4", "win_vld", 64'(win_vld_o), 64'(m_vld));
    chk("R4", "win_id", 64'(win_id_o), 64'(m_id));
    chk("R5", "lock", 64'(lock_o), 64'(m_lock));
    chk("R6", "prev_lock", 64'(prev_lock_o), 64'(m_prev));
    chk("R9", "bypass", 64'(bypass_o), 64'(m_byp));
    chk("R3", "run", 64'(run_prio_o), 64'(m_run));
    chk("R3", "rd_prio", 64'(rd_prio_o), 64'(m_prio[int'(rd_line_i)]));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    raise_i = '0; clr_i = '0; hard_req_i = 0; cmd_vld_i = 0; cmd_op_i = '0;
  endtask

  task automatic cmd(int op, int line, int data);
    cmd_vld_i = 1; cmd_op_i = 3'(op); cmd_line_i = IDW'(line); cmd_data_i = RW'(data);
    tick();
  endtask

  task automatic raise_lines(bit [63:0] v);
    raise_i = v;
    tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R8: reset state
    rd_line_i = 6'd17;
    chk("R8", "mask", mask_o, 0);
    chk("R8", "premask", premask_o, 0);
    chk("R8", "pending", pend_o, 0);
    chk("R8", "lock", 64'(lock_o), 0);
    chk("R8", "bypass", 64'(bypass_o), 0);
    chk("R8", "prio", 64'(rd_prio_o), 255);
    chk("R8", "run", 64'(run_prio_o), 256);
    chk("R8", "win", 64'(win_vld_o), 0);
    chk("R8", "wake", 64'(wake_o), 0);
    rst_n = 1;
    tick();

    // R10/R1: disabled line raise wakes, latched only
    raise_lines(64'd1 << 5);
    chk("R10", "masked raise wake", 64'(wake_o), 1);
    chk("R1", "masked raise pend", 64'(pend_o[5]), 0);
    // R2: enable of a latched line re-raises
    cmd(3, 5, 10);
    cmd(1, 5, 0);
    chk("R2", "re-raise wake", 64'(wake_o), 1);
    chk("R2", "re-raise pend", 64'(pend_o[5]), 1);
    tick();
    chk("R4", "single winner", 64'(win_id_o), 5);

    // R4: tie goes to lower line
    cmd(3, 9, 3); cmd(3, 20, 3); cmd(1, 9, 0); cmd(1, 20, 0);
    raise_lines((64'd1 << 9) | (64'd1 << 20));
    tick();
    chk("R4", "tie winner", 64'(win_id_o), 9);
    // R3: strict compare against running level
    cmd(4, 0, 3); tick();
    chk("R3", "equal to running blocks", 64'(win_vld_o), 0);
    cmd(4, 0, 4); tick();
    chk("R3", "below running wins", 64'(win_id_o), 9);
    cmd(4, 0, 256);

    // R5: lock holds back winner and wake
    cmd(1, 30, 0);
    cmd(5, 0, 1);
    raise_lines(64'd1 << 30);
    chk("R5", "locked raise no wake", 64'(wake_o), 0);
    chk("R5", "locked raise recorded", 64'(premask_o[30]), 1);
    tick();
    chk("R5", "locked winner id", 64'(win_id_o), 127);
    // R6: unlock with pending wakes, previous value returned
    cmd(5, 0, 0);
    chk("R6", "unlock wake", 64'(wake_o), 1);
    chk("R6", "prev lock", 64'(prev_lock_o), 1);
    cmd(5, 0, 0);
    chk("R6", "no change no wake", 64'(wake_o), 0);

    // R9: override lets one raise through a held lock
    cmd(5, 0, 1);
    hard_req_i = 1; tick();
    chk("R9", "armed", 64'(bypass_o), 1);
    raise_lines(64'd1 << 40);
    chk("R9", "bypass wake", 64'(wake_o), 1);
    chk("R9", "consumed", 64'(bypass_o), 0);
    raise_lines(64'd1 << 41);
    chk("R9", "second locked raise", 64'(wake_o), 0);
    cmd(5, 0, 0);

    // R7: clears
    clr_i = 64'd1 << 5; tick();
    chk("R7", "line clear", 64'({premask_o[5], pend_o[5]}), 0);
    cmd(6, 0, 0);
    chk("R7", "clr enabled pend", pend_o, 0);
    chk("R7", "clr enabled keeps disabled", 64'(premask_o[40]), 1);
    cmd(7, 0, 0);
    chk("R7", "clr all", premask_o, 0);

    // R11: set beats clear
    raise_i = 64'd1 << 12; clr_i = 64'd1 << 12; tick();
    chk("R11", "set wins", 64'(premask_o[12]), 1);

    // R3: top line, urgency 255 still beats idle level 256
    cmd(1, 63, 0);
    raise_lines(64'd1 << 63);
    tick();
    chk("R3", "lowest urgency vs idle", 64'(win_id_o), 63);
    // R12: disable hides pending line from arbitration
    cmd(2, 63, 0); tick();
    chk("R12", "disabled line no win", 64'(win_vld_o), 0);

    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) raise_i = 64'd1 << $urandom_range(0, 63);
      if (r < 3)  raise_i |= 64'd1 << $urandom_range(0, 63);
      if ($urandom_range(0, 99) < 8) clr_i = 64'd1 << $urandom_range(0, 63);
      if ($urandom_range(0, 99) < 3) hard_req_i = 1;
      rd_line_i = IDW'($urandom_range(0, 63));
      if ($urandom_range(0, 99) < 40) begin
        cmd_vld_i = 1;
        cmd_op_i = 3'($urandom_range(0, 7));
        if (cmd_op_i >= 3'd6 && $urandom_range(0, 9) != 0) cmd_op_i = 3'd1;
        cmd_line_i = IDW'($urandom_range(0, 63));
        cmd_data_i = RW'($urandom_range(0, 256));
      end
      tick();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule